// File: doc/BRIEF.md
# Overlapped Block Load Sequencer

This block sequences the input and output phases of one transform engine that sits in a daisy chain of identical engines, all fed from a single sample stream. When a start event arrives, the sequencer accepts one block of samples, one per input strobe. It presents a write index for each accepted sample so that the neighbouring storage can place the sample. While the block is loading, it holds a load flag high. The flag drops at a programmable point in the load, and the next engine in the chain takes that falling edge as its own start. Releasing the flag early lets the next engine begin while the current one is still loading, so consecutive blocks overlap by 0%, 50% or 75%.

After the last sample of the block, the sequencer waits a programmable number of clocks while the transform runs. It then issues output strobes, one per clock. The first four of these prime the output path. The rest carry the transform result bins in order. The three phases (load, transform wait, dump) never overlap inside one engine.

Any start event that arrives while the engine is busy is dropped. A sticky flag records that the start was missed. In a closed ring, the load flag of the last engine is fed back to the chain input of the first engine. A separate kick input, when enabled by a configuration bit, can launch that ring.

Top module: `ovl_load_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) forces the following state: phase_o = 0 (idle), load_flag_o = 0, dump_stb_o = 0, smp_take_o = 0 and miss_o = 0. Any block in progress is abandoned.
- R2: In idle, a start event is either a falling edge of chain_en_i (high in one cycle, low in the next), or a rising edge of kick_i when cfg_kick_en_i = 1. A rising edge of kick_i has no effect when cfg_kick_en_i = 0. On the clock after a start event, phase_o becomes 1 (load) and load_flag_o rises.
- R3: During load, each cycle with in_stb_i high accepts one sample. In that cycle smp_take_o is high and smp_idx_o equals the number of samples already accepted in this block (0 to BLK_LEN-1). In any other phase, smp_take_o stays low and in_stb_i has no effect.
- R4: load_flag_o falls on the clock after the accepted sample that brings the block count to the release point. The release point is BLK_LEN/4 for cfg_overlap_i = 2, BLK_LEN/2 for cfg_overlap_i = 1, and BLK_LEN for cfg_overlap_i = 0 or 3. cfg_overlap_i is sampled at the start event.
- R5: After the sample numbered BLK_LEN, phase_o is 2 (transform) for exactly W+1 cycles. W is cfg_xform_wait_i as sampled in the cycle of that last sample. The phases always advance idle, load, transform, dump, idle.
- R6: In the dump phase (phase_o = 3), dump_stb_o is high on every cycle, for exactly BLK_LEN+4 cycles. On the first 4 strobes dump_valid_o is low. On the following BLK_LEN strobes dump_valid_o is high and dump_idx_o counts 0 to BLK_LEN-1. The phase then returns to idle.
- R7: A start event that arrives while phase_o is not 0 neither restarts nor alters the running sequence. It sets miss_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_overlap_i | input | 2 | Overlap select: 0 or 3 none, 1 half, 2 three quarters |
| cfg_kick_en_i | input | 1 | Allows kick_i to launch a block |
| cfg_xform_wait_i | input | WAIT_W | Transform wait count W |
| chain_en_i | input | 1 | Chain enable; falling edge starts a load |
| kick_i | input | 1 | Separate launch input; rising edge starts a load when enabled |
| in_stb_i | input | 1 | Input sample strobe |
| load_flag_o | output | 1 | Load flag; its falling edge starts the next engine |
| smp_take_o | output | 1 | Sample accepted this cycle |
| smp_idx_o | output | log2(BLK_LEN) | Write index of the accepted sample |
| dump_stb_o | output | 1 | Output strobe |
| dump_valid_o | output | 1 | Output strobe carries a result bin |
| dump_idx_o | output | log2(BLK_LEN) | Bin index of a valid output strobe |
| phase_o | output | 2 | 0 idle, 1 load, 2 transform, 3 dump |
| miss_o | output | 1 | Sticky: a start event arrived while busy |

## Verification
The hardest situation to reach from the ports is a start event that lands while the engine is busy. The stimulus must raise kick_i a few cycles into a load, with the kick enabled. It must then show that the block still finishes with its full count of strobes and that the missed-start flag stays set across later blocks. The early flag release under irregular input strobes is the other delicate case. Pseudo-random gaps in in_stb_i, under each overlap setting, move the flag edge away from a fixed cycle. The model tracks the edge by the count of accepted samples, not by time.

// File: rtl/ovl_seq_pkg.sv
package ovl_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_XFORM = 2'd2,
        PH_DUMP  = 2'd3
    } phase_e;

    localparam logic [1:0] OVL_HALF    = 2'd1;
    localparam logic [1:0] OVL_3QUART  = 2'd2;

    // Sample count at which the load flag is released.
    function automatic int unsigned release_point(input logic [1:0] sel,
                                                  input int unsigned blk);
        case (sel)
            OVL_HALF:   return blk / 2;
            OVL_3QUART: return blk / 4;
            default:    return blk;
        endcase
    endfunction

endpackage

// File: rtl/ovl_start_ctl.sv
module ovl_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic chain_en_i,
    input  logic kick_i,
    input  logic kick_en_i,
    output logic start_o
);

    typedef struct packed {
        logic en_prev;
        logic kick_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.en_prev   = chain_en_i;
        st_d.kick_prev = kick_i;
        start_o = (st_q.en_prev & ~chain_en_i)
                | (kick_en_i & kick_i & ~st_q.kick_prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en_prev   <= 1'b0;
            st_q.kick_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ovl_load_ctr.sv
module ovl_load_ctr
    import ovl_seq_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int IDX_W   = $clog2(BLK_LEN),
    parameter int CNT_W   = $clog2(BLK_LEN) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             take_i,
    input  logic [1:0]       ovl_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             flag_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BLK_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic [1:0]       sel;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        rel  = CNT_W'(release_point(st_q.sel, BLK_LEN));
        nxt  = st_q.cnt + 1'b1;
        if (go_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b1;
            st_d.sel  = ovl_i;
        end else if (take_i) begin
            st_d.cnt = nxt;
            if (nxt == rel) begin
                st_d.flag = 1'b0;
            end
        end
        last_o = take_i && (nxt == FULL);
        idx_o  = st_q.cnt[IDX_W-1:0];
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.flag <= 1'b0;
            st_q.sel  <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ovl_dump_ctr.sv
module ovl_dump_ctr #(
    parameter int BLK_LEN = 64,
    parameter int PRIME_N = 4,
    parameter int IDX_W   = $clog2(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    output logic             stb_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    localparam int TOTAL = BLK_LEN + PRIME_N;
    localparam int DW    = $clog2(TOTAL + 1);
    localparam logic [DW-1:0] LAST_CNT  = DW'(TOTAL - 1);
    localparam logic [DW-1:0] PRIME_CNT = DW'(PRIME_N);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] bin;

    always_comb begin
        st_d    = st_q;
        last_o  = en_i && (st_q.cnt == LAST_CNT);
        if (!en_i || last_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        bin     = st_q.cnt - PRIME_CNT;
        stb_o   = en_i;
        valid_o = en_i && (st_q.cnt >= PRIME_CNT);
        idx_o   = bin[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ovl_load_seq.sv
module ovl_load_seq
    import ovl_seq_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int WAIT_W  = 16,
    parameter int PRIME_N = 4,
    parameter int IDX_W   = $clog2(BLK_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_overlap_i,
    input  logic              cfg_kick_en_i,
    input  logic [WAIT_W-1:0] cfg_xform_wait_i,
    input  logic              chain_en_i,
    input  logic              kick_i,
    input  logic              in_stb_i,
    output logic              load_flag_o,
    output logic              smp_take_o,
    output logic [IDX_W-1:0]  smp_idx_o,
    output logic              dump_stb_o,
    output logic              dump_valid_o,
    output logic [IDX_W-1:0]  dump_idx_o,
    output logic [1:0]        phase_o,
    output logic              miss_o
);

    typedef struct packed {
        phase_e            phase;
        logic [WAIT_W-1:0] wait_cnt;
        logic              miss;
    } st_t;

    st_t  st_d, st_q;
    logic start_ev;
    logic go;
    logic take;
    logic load_last;
    logic dump_en;
    logic dump_last;

    ovl_start_ctl u_start (
        .clk        (clk),
        .rst        (rst),
        .chain_en_i (chain_en_i),
        .kick_i     (kick_i),
        .kick_en_i  (cfg_kick_en_i),
        .start_o    (start_ev)
    );

    ovl_load_ctr #(
        .BLK_LEN (BLK_LEN),
        .IDX_W   (IDX_W)
    ) u_load (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .take_i (take),
        .ovl_i  (cfg_overlap_i),
        .idx_o  (smp_idx_o),
        .flag_o (load_flag_o),
        .last_o (load_last)
    );

    ovl_dump_ctr #(
        .BLK_LEN (BLK_LEN),
        .PRIME_N (PRIME_N),
        .IDX_W   (IDX_W)
    ) u_dump (
        .clk     (clk),
        .rst     (rst),
        .en_i    (dump_en),
        .stb_o   (dump_stb_o),
        .valid_o (dump_valid_o),
        .idx_o   (dump_idx_o),
        .last_o  (dump_last)
    );

    always_comb begin
        st_d    = st_q;
        go      = start_ev && (st_q.phase == PH_IDLE);
        take    = in_stb_i && (st_q.phase == PH_LOAD);
        dump_en = (st_q.phase == PH_DUMP);
        if (start_ev && (st_q.phase != PH_IDLE)) begin
            st_d.miss = 1'b1;
        end
        case (st_q.phase)
            PH_IDLE: begin
                if (go) begin
                    st_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                if (load_last) begin
                    st_d.phase    = PH_XFORM;
                    st_d.wait_cnt = cfg_xform_wait_i;
                end
            end
            PH_XFORM: begin
                if (st_q.wait_cnt == '0) begin
                    st_d.phase = PH_DUMP;
                end else begin
                    st_d.wait_cnt = st_q.wait_cnt - 1'b1;
                end
            end
            default: begin
                if (dump_last) begin
                    st_d.phase = PH_IDLE;
                end
            end
        endcase
        smp_take_o = take;
        phase_o    = st_q.phase;
        miss_o     = st_q.miss;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase    <= PH_IDLE;
            st_q.wait_cnt <= '0;
            st_q.miss     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ovl_load_seq_chk.sv
module ovl_load_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase_o,
    input logic       load_flag_o,
    input logic       smp_take_o,
    input logic       dump_stb_o,
    input logic       dump_valid_o,
    input logic       miss_o
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (phase_o == 2'd0) && !load_flag_o && !dump_stb_o && !miss_o); // R1

    AST_FLAG_RISE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(load_flag_o) |-> (phase_o == 2'd1) && ($past(phase_o) == 2'd0)); // R2

    AST_TAKE_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        smp_take_o |-> (phase_o == 2'd1)); // R3

    AST_FLAG_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_flag_o |-> (phase_o == 2'd1)); // R4

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> (phase_o == 2'($past(phase_o) + 2'd1))); // R5

    AST_VALID_HAS_STB: assert property (@(posedge clk) disable iff (rst)
        dump_valid_o |-> dump_stb_o); // R6

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
        miss_o |=> miss_o); // R7

endmodule

bind ovl_load_seq ovl_load_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .phase_o      (phase_o),
    .load_flag_o  (load_flag_o),
    .smp_take_o   (smp_take_o),
    .dump_stb_o   (dump_stb_o),
    .dump_valid_o (dump_valid_o),
    .miss_o       (miss_o)
);

// File: tb/sim_ovl_load_seq.sv
module sim_ovl_load_seq;

    localparam int BLK = 16;
    localparam int WW  = 8;
    localparam int IW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_overlap = 2'd0;
    logic          cfg_kick_en = 1'b0;
    logic [WW-1:0] cfg_wait = '0;
    logic          chain_en = 1'b0;
    logic          kick = 1'b0;
    logic          in_stb = 1'b0;
    logic          load_flag_o, smp_take_o, dump_stb_o, dump_valid_o, miss_o;
    logic [IW-1:0] smp_idx_o, dump_idx_o;
    logic [1:0]    phase_o;

    int checks = 0;
    int errors = 0;
    int stb_mode = 2;
    bit done = 0;

    always #5 clk = ~clk;

    ovl_load_seq #(.BLK_LEN(BLK), .WAIT_W(WW)) u0 (
        .clk(clk), .rst(rst), .cfg_overlap_i(cfg_overlap), .cfg_kick_en_i(cfg_kick_en),
        .cfg_xform_wait_i(cfg_wait), .chain_en_i(chain_en), .kick_i(kick), .in_stb_i(in_stb),
        .load_flag_o(load_flag_o), .smp_take_o(smp_take_o), .smp_idx_o(smp_idx_o),
        .dump_stb_o(dump_stb_o), .dump_valid_o(dump_valid_o), .dump_idx_o(dump_idx_o),
        .phase_o(phase_o), .miss_o(miss_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rel_of(input int sel);
        if (sel == 1) return BLK / 2;
        if (sel == 2) return BLK / 4;
        return BLK;
    endfunction

    // Behavioural reference model, stepped once per cycle just before the edge.
    int  m_ph = 0, m_cnt = 0, m_rel = BLK, m_wait = 0, m_dn = 0;
    bit  m_flag = 0, m_miss = 0, m_en_prev = 0, m_kick_prev = 1;

    always @(negedge clk) begin
        #4;
        if (!rst) begin
            chk(phase_o == 2'(m_ph), "R5 phase", phase_o, m_ph);
            chk(load_flag_o == m_flag, "R4 load flag", load_flag_o, m_flag);
            chk(smp_take_o == (m_ph == 1 && in_stb), "R3 take", smp_take_o, m_ph == 1 && in_stb);
            if (m_ph == 1 && in_stb)
                chk(smp_idx_o == IW'(m_cnt), "R3 index", smp_idx_o, m_cnt);
            chk(dump_stb_o == (m_ph == 3), "R6 strobe", dump_stb_o, m_ph == 3);
            chk(dump_valid_o == (m_ph == 3 && m_dn >= 4), "R6 valid", dump_valid_o,
                m_ph == 3 && m_dn >= 4);
            if (m_ph == 3 && m_dn >= 4)
                chk(dump_idx_o == IW'(m_dn - 4), "R6 bin", dump_idx_o, m_dn - 4);
            chk(miss_o == m_miss, "R7 miss", miss_o, m_miss);
        end
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_wait = 0; m_dn = 0;
            m_flag = 0; m_miss = 0; m_en_prev = 0; m_kick_prev = 1;
        end else begin
            bit st;
            st = (m_en_prev && !chain_en) || (cfg_kick_en && kick && !m_kick_prev);
            if (st && m_ph != 0) m_miss = 1;
            case (m_ph)
                0: if (st) begin
                    m_ph = 1; m_flag = 1; m_cnt = 0; m_rel = rel_of(cfg_overlap);
                end
                1: if (in_stb) begin
                    m_cnt++;
                    if (m_cnt == m_rel) m_flag = 0;
                    if (m_cnt == BLK) begin m_ph = 2; m_wait = cfg_wait; end
                end
                2: if (m_wait == 0) begin m_ph = 3; m_dn = 0; end else m_wait--;
                default: begin
                    m_dn++;
                    if (m_dn == BLK + 4) begin m_ph = 0; m_dn = 0; end
                end
            endcase
            m_en_prev = chain_en;
            m_kick_prev = kick;
        end
    end

    always @(negedge clk) begin
        case (stb_mode)
            0: in_stb <= 1'b1;
            1: in_stb <= 1'($urandom % 2);
            default: in_stb <= 1'b0;
        endcase
    end

    task automatic run_block(input int ovl, input int w, input int mode,
                             input bit via_kick, input bit poke);
        int dumps;
        dumps = 0;
        @(negedge clk);
        cfg_overlap = 2'(ovl);
        cfg_wait = WW'(w);
        stb_mode = mode;
        if (via_kick) begin cfg_kick_en = 1'b1; kick = 1'b1; end
        else chain_en = 1'b1;
        if (poke) cfg_kick_en = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        chain_en = 1'b0;
        if (!via_kick) @(negedge clk);
        #4 chk(phase_o == 2'd1 && load_flag_o, "R2 start", phase_o, 1);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            kick = (poke && i == 3);
            #4;
            if (dump_stb_o) dumps++;
            if (phase_o == 2'd0) break;
        end
        chk(dumps == BLK + 4, "R6 strobe count", dumps, BLK + 4);
        chk(phase_o == 2'd0, "R6 back to idle", phase_o, 0);
        stb_mode = 2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #4;
        chk(phase_o == 2'd0, "R1 phase", phase_o, 0);
        chk(!load_flag_o && !dump_stb_o && !smp_take_o, "R1 outputs", load_flag_o, 0);
        chk(!miss_o, "R1 miss", miss_o, 0);

        run_block(0, 3, 0, 0, 0);
        chk(!miss_o, "R7 no miss", miss_o, 0);
        run_block(1, 0, 1, 0, 0);
        run_block(2, 5, 0, 1, 1);
        chk(miss_o, "R7 missed start", miss_o, 1);
        run_block(3, 10, 1, 0, 0);
        chk(miss_o, "R7 sticky", miss_o, 1);

        // kick with launch disabled
        @(negedge clk);
        cfg_kick_en = 1'b0;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        repeat (3) @(negedge clk);
        #4 chk(phase_o == 2'd0, "R2 kick disabled", phase_o, 0);

        // reset during a load
        @(negedge clk);
        chain_en = 1'b1;
        stb_mode = 0;
        @(negedge clk);
        chain_en = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        stb_mode = 2;
        @(negedge clk);
        #4;
        chk(phase_o == 2'd0 && !load_flag_o, "R1 mid-load reset", phase_o, 0);
        chk(!miss_o, "R1 miss cleared", miss_o, 0);

        run_block(2, 1, 1, 0, 0);
        run_block(1, 2, 0, 1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule